// File: doc/BRIEF.md
# Double-Buffered Video Memory Switch

This block sits between a host processor bus and two frame memory banks. At any moment one bank is the display bank, which the video output reads, and the other is the back bank. The host has unrestricted read and write access to the back bank. To the host the pair looks like a single memory: its address, write data, output-enable and write-enable are steered to whichever bank is hidden. The display read port always addresses the bank on screen.

A flip request from the host is held as pending. The swap takes place at the next start of vertical blank, so a frame that is being scanned out is never torn. The host data path turns around with the output-enable: the bank drives the host while output-enable is high, and the host drives the bank otherwise. When the path turns from writing to reading, read data is marked valid only after two dead cycles. The display side runs at the video frame rate of 60 frames per second. Its timing generator supplies the vertical-blank pulse and is outside this block.

Top module: `vidmem_switch`

## Requirements
- R1: After reset, bank 0 is displayed (`disp_bank` = 0) and bank 1 is the back bank, `flip_pending` is 0 and `host_rvalid` is 0.
- R2: While `host_oe` is 0, `host_we` asserts the write-enable of the back bank only, carrying `host_addr` and `host_wdata`. The display bank's write-enable is never asserted.
- R3: While `host_oe` is 1, no bank write-enable is asserted, whatever `host_we` is. `host_dir` is 1 (bank to host) exactly when `host_oe` is 1.
- R4: The display bank's address is `disp_addr` and `disp_data` returns that bank's read data. The back bank's address is `host_addr`.
- R5: A one-cycle `host_flip` sets `flip_pending` at the next clock edge. Bank roles do not change until a `vblank_start` cycle arrives.
- R6: A `vblank_start` cycle while `flip_pending` is 1 swaps the bank roles and clears `flip_pending` at the same edge. A `host_flip` in that same cycle is kept pending for the next blank.
- R7: A `vblank_start` cycle while `flip_pending` is 0 leaves the bank roles unchanged.
- R8: After `host_oe` rises, `host_rvalid` stays 0 for two clock edges and becomes 1 after the second edge of continuous `host_oe`. `host_rdata` is the back bank's read data while `host_rvalid` is 1 and 0 otherwise.
- R9: A bank swap restarts the turnaround, so `host_rvalid` drops to 0 after the swap edge and returns two edges later if `host_oe` stays high.
- R10: The back bank's output-enable equals `host_oe`. The display bank's output-enable is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host address into the back bank |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data to host, 0 unless valid |
| host_dir | output | 1 | Data direction, 1 = bank to host |
| host_rvalid | output | 1 | Read data valid after turnaround |
| host_oe | input | 1 | Host output-enable (read) |
| host_we | input | 1 | Host write-enable |
| host_flip | input | 1 | Flip request pulse |
| vblank_start | input | 1 | Start of vertical blank pulse |
| flip_pending | output | 1 | Flip requested, not yet applied |
| disp_bank | output | 1 | Index of the displayed bank |
| disp_addr | input | ADDR_W | Display read address |
| disp_data | output | DATA_W | Display read data |
| b0_addr | output | ADDR_W | Bank 0 address |
| b0_wdata | output | DATA_W | Bank 0 write data |
| b0_oe | output | 1 | Bank 0 output-enable |
| b0_we | output | 1 | Bank 0 write-enable |
| b0_rdata | input | DATA_W | Bank 0 read data |
| b1_addr | output | ADDR_W | Bank 1 address |
| b1_wdata | output | DATA_W | Bank 1 write data |
| b1_oe | output | 1 | Bank 1 output-enable |
| b1_we | output | 1 | Bank 1 write-enable |
| b1_rdata | input | DATA_W | Bank 1 read data |

## Verification
A corrupted bank-select register shows at once on the bank ports. Host writes land in the displayed bank, and `disp_data` returns contents the host just wrote, so a comparison against a bench-side model of both banks catches it in the same cycle. A pending flag that is stuck or lost shows as a `disp_bank` that changes at the wrong vertical blank, or does not change at all, one edge after the blank pulse. A wrong turnaround count shows as `host_rvalid` or nonzero `host_rdata` one edge early or late after `host_oe` rises or after a swap.

// File: rtl/vidmem_pkg.sv
package vidmem_pkg;
  typedef logic bank_id_t;
  localparam int unsigned NUM_BANKS = 2;
  localparam bank_id_t RESET_DISP_BANK = 1'b0;

  function automatic bank_id_t other_bank(input bank_id_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/vms_flip_ctrl.sv
module vms_flip_ctrl
  import vidmem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flip_req,
  input  logic     vblank,
  output bank_id_t disp_sel,
  output logic     pending,
  output logic     swap
);
  bank_id_t disp_q, disp_d;
  logic     pend_q, pend_d;

  always_comb begin
    swap   = pend_q & vblank;
    disp_d = disp_q;
    if (swap) disp_d = other_bank(disp_q);
    // a request in the swap cycle is kept for the next blank
    pend_d = flip_req | (pend_q & ~vblank);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= RESET_DISP_BANK;
      pend_q <= 1'b0;
    end else begin
      disp_q <= disp_d;
      pend_q <= pend_d;
    end
  end

  assign disp_sel = disp_q;
  assign pending  = pend_q;
endmodule

// File: rtl/vms_turnaround.sv
module vms_turnaround #(
  parameter int unsigned TURN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic restart,
  output logic valid
);
  localparam int unsigned CNT_W = $clog2(TURN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TURN_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!rd_en || restart)    cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign valid = rd_en && (cnt_q == CNT_MAX);
endmodule

// File: rtl/vms_bank_router.sv
module vms_bank_router
  import vidmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  bank_id_t                           disp_sel,
  input  logic [ADDR_W-1:0]                  host_addr,
  input  logic [DATA_W-1:0]                  host_wdata,
  input  logic                               host_oe,
  input  logic                               host_we,
  input  logic [ADDR_W-1:0]                  disp_addr,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_rdata,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]   bank_addr,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_wdata,
  output logic [NUM_BANKS-1:0]               bank_oe,
  output logic [NUM_BANKS-1:0]               bank_we,
  output logic [DATA_W-1:0]                  back_rdata,
  output logic [DATA_W-1:0]                  disp_rdata
);
  bank_id_t back_sel;
  logic     wr_ok;

  assign back_sel = other_bank(disp_sel);
  assign wr_ok    = host_we & ~host_oe;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic is_back;
    assign is_back       = (back_sel == bank_id_t'(k));
    assign bank_addr[k]  = is_back ? host_addr : disp_addr;
    assign bank_wdata[k] = host_wdata;
    assign bank_oe[k]    = is_back ? host_oe : 1'b1;
    assign bank_we[k]    = is_back & wr_ok;
  end

  assign back_rdata = bank_rdata[back_sel];
  assign disp_rdata = bank_rdata[disp_sel];
endmodule

// File: rtl/vidmem_switch.sv
module vidmem_switch
  import vidmem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_dir,
  output logic              host_rvalid,
  input  logic              host_oe,
  input  logic              host_we,
  input  logic              host_flip,
  input  logic              vblank_start,
  output logic              flip_pending,
  output logic              disp_bank,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [DATA_W-1:0] disp_data,
  output logic [ADDR_W-1:0] b0_addr,
  output logic [DATA_W-1:0] b0_wdata,
  output logic              b0_oe,
  output logic              b0_we,
  input  logic [DATA_W-1:0] b0_rdata,
  output logic [ADDR_W-1:0] b1_addr,
  output logic [DATA_W-1:0] b1_wdata,
  output logic              b1_oe,
  output logic              b1_we,
  input  logic [DATA_W-1:0] b1_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bank_id_t disp_sel;
  logic     swap;

  vms_flip_ctrl u_flip (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flip_req (host_flip),
    .vblank   (vblank_start),
    .disp_sel (disp_sel),
    .pending  (flip_pending),
    .swap     (swap)
  );

  vms_turnaround #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (host_oe),
    .restart (swap),
    .valid   (host_rvalid)
  );

  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_addr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_wdata;
  logic [NUM_BANKS-1:0]             bank_oe;
  logic [NUM_BANKS-1:0]             bank_we;
  logic [DATA_W-1:0]                back_rdata;

  assign bank_rdata[0] = b0_rdata;
  assign bank_rdata[1] = b1_rdata;

  vms_bank_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .disp_sel   (disp_sel),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_oe    (host_oe),
    .host_we    (host_we),
    .disp_addr  (disp_addr),
    .bank_rdata (bank_rdata),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata),
    .bank_oe    (bank_oe),
    .bank_we    (bank_we),
    .back_rdata (back_rdata),
    .disp_rdata (disp_data)
  );

  assign b0_addr  = bank_addr[0];
  assign b0_wdata = bank_wdata[0];
  assign b0_oe    = bank_oe[0];
  assign b0_we    = bank_we[0];
  assign b1_addr  = bank_addr[1];
  assign b1_wdata = bank_wdata[1];
  assign b1_oe    = bank_oe[1];
  assign b1_we    = bank_we[1];

  assign host_dir   = host_oe;
  assign host_rdata = host_rvalid ? back_rdata : '0;
  assign disp_bank  = disp_sel;
endmodule

// File: rtl/vidmem_switch_chk.sv
module vidmem_switch_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_oe,
  input logic              host_flip,
  input logic              vblank_start,
  input logic              flip_pending,
  input logic              disp_bank,
  input logic              host_rvalid,
  input logic [DATA_W-1:0] host_rdata,
  input logic              b0_we,
  input logic              b1_we,
  input logic              b0_oe,
  input logic              b1_oe
);
  // R2
  display_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bank ? !b1_we : !b0_we));

  // R3
  read_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |-> !(b0_we || b1_we));

  // R10
  display_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bank ? b1_oe : b0_oe));

  // R6
  swap_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_pending && vblank_start && !host_flip) |=>
      (!flip_pending && disp_bank != $past(disp_bank)));

  // R7
  no_swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_pending |=> $stable(disp_bank));

  // R5
  request_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_flip |=> flip_pending);

  // R8
  rise_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_oe) |-> !host_rvalid);

  // R8
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rvalid |-> (host_rdata == '0));
endmodule

bind vidmem_switch vidmem_switch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .host_oe      (host_oe),
  .host_flip    (host_flip),
  .vblank_start (vblank_start),
  .flip_pending (flip_pending),
  .disp_bank    (disp_bank),
  .host_rvalid  (host_rvalid),
  .host_rdata   (host_rdata),
  .b0_we        (b0_we),
  .b1_we        (b1_we),
  .b0_oe        (b0_oe),
  .b1_oe        (b1_oe)
);

// File: tb/vidmem_switch_bench.sv
`timescale 1ns/1ps
module vidmem_switch_bench;
  localparam int AW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] host_addr, disp_addr;
  logic [DW-1:0] host_wdata, host_rdata, disp_data;
  logic          host_dir, host_rvalid, host_oe, host_we, host_flip, vblank_start;
  logic          flip_pending, disp_bank;
  logic [AW-1:0] b0_addr, b1_addr;
  logic [DW-1:0] b0_wdata, b1_wdata, b0_rdata, b1_rdata;
  logic          b0_oe, b0_we, b1_oe, b1_we;

  logic [DW-1:0] mem0 [0:(1<<AW)-1];
  logic [DW-1:0] mem1 [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (b0_we) mem0[b0_addr] <= b0_wdata;
    if (b1_we) mem1[b1_addr] <= b1_wdata;
  end
  assign b0_rdata = mem0[b0_addr];
  assign b1_rdata = mem1[b1_addr];

  vidmem_switch u_vidmem_switch (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_dir(host_dir), .host_rvalid(host_rvalid), .host_oe(host_oe),
    .host_we(host_we), .host_flip(host_flip), .vblank_start(vblank_start),
    .flip_pending(flip_pending), .disp_bank(disp_bank),
    .disp_addr(disp_addr), .disp_data(disp_data),
    .b0_addr(b0_addr), .b0_wdata(b0_wdata), .b0_oe(b0_oe), .b0_we(b0_we), .b0_rdata(b0_rdata),
    .b1_addr(b1_addr), .b1_wdata(b1_wdata), .b1_oe(b1_oe), .b1_we(b1_we), .b1_rdata(b1_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R1 disp_bank", disp_bank, 0);
    check("R1 pending", flip_pending, 0);
    check("R1 rvalid", host_rvalid, 0);
    check("R3 dir idle", host_dir, 0);
    check("R10 b0_oe display", b0_oe, 1);
  endtask

  task automatic t_write_back();
    @(negedge clk);
    host_addr = 12'h123; host_wdata = 8'hA5; host_we = 1; disp_addr = 12'h123;
    #1;
    check("R2 b1_we", b1_we, 1);
    check("R2 b0_we", b0_we, 0);
    check("R4 b1_addr", b1_addr, 12'h123);
    edge_sample();
    check("R2 back written", mem1[12'h123], 8'hA5);
    check("R2 display kept", mem0[12'h123], 8'h3C);
    check("R4 disp_data", disp_data, 8'h3C);
    @(negedge clk); host_we = 0;
  endtask

  task automatic t_read_turn();
    @(negedge clk);
    host_addr = 12'h123; host_oe = 1; host_we = 1;
    #1;
    check("R3 dir read", host_dir, 1);
    check("R3 we gated", b1_we | b0_we, 0);
    check("R10 back oe", b1_oe, 1);
    check("R8 dead0 valid", host_rvalid, 0);
    check("R8 dead0 data", host_rdata, 0);
    edge_sample();
    check("R8 dead1 valid", host_rvalid, 0);
    check("R8 dead1 data", host_rdata, 0);
    edge_sample();
    check("R8 valid", host_rvalid, 1);
    check("R8 data", host_rdata, 8'hA5);
    check("R3 no write on read", mem1[12'h123], 8'hA5);
    @(negedge clk); host_oe = 0; host_we = 0;
    #1;
    check("R8 drop", host_rvalid, 0);
    check("R10 back oe low", b1_oe, 0);
  endtask

  task automatic t_flip();
    @(negedge clk); host_flip = 1;
    edge_sample();
    check("R5 pending", flip_pending, 1);
    check("R5 no swap yet", disp_bank, 0);
    @(negedge clk); host_flip = 0;
    edge_sample(); edge_sample();
    check("R5 wait blank", disp_bank, 0);
    @(negedge clk); vblank_start = 1;
    edge_sample();
    check("R6 swapped", disp_bank, 1);
    check("R6 cleared", flip_pending, 0);
    @(negedge clk); vblank_start = 0; disp_addr = 12'h123; host_addr = 12'h040; host_wdata = 8'h77; host_we = 1;
    #1;
    check("R4 disp from bank1", disp_data, 8'hA5);
    check("R2 b0 now back", b0_we, 1);
    check("R2 b1 display", b1_we, 0);
    edge_sample();
    check("R2 write bank0", mem0[12'h040], 8'h77);
    @(negedge clk); host_we = 0;
  endtask

  task automatic t_idle_blank();
    @(negedge clk); vblank_start = 1;
    edge_sample();
    check("R7 no swap", disp_bank, 1);
    @(negedge clk); vblank_start = 0;
  endtask

  task automatic t_same_cycle();
    // request in a blank cycle with nothing pending: held for next blank
    @(negedge clk); host_flip = 1; vblank_start = 1;
    edge_sample();
    check("R7 same-cycle no swap", disp_bank, 1);
    check("R6 held", flip_pending, 1);
    // swap plus new request together: swap and stay pending
    @(negedge clk); host_flip = 1; vblank_start = 1;
    edge_sample();
    check("R6 swap again", disp_bank, 0);
    check("R6 new request kept", flip_pending, 1);
    @(negedge clk); host_flip = 0; vblank_start = 0;
  endtask

  task automatic t_swap_restart();
    @(negedge clk); host_oe = 1; host_addr = 12'h123;
    edge_sample(); edge_sample();
    check("R8 valid before swap", host_rvalid, 1);
    @(negedge clk); vblank_start = 1;
    edge_sample();
    check("R9 swap done", disp_bank, 1);
    check("R9 restart", host_rvalid, 0);
    @(negedge clk); vblank_start = 0;
    edge_sample();
    check("R9 still dead", host_rvalid, 0);
    edge_sample();
    check("R9 valid again", host_rvalid, 1);
    check("R9 data from bank0", host_rdata, mem0[12'h123]);
    @(negedge clk); host_oe = 0;
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      mem0[i] = 8'h3C;
      mem1[i] = 8'h00;
    end
    rst_n = 0; host_addr = '0; host_wdata = '0; host_oe = 0; host_we = 0;
    host_flip = 0; vblank_start = 0; disp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_write_back();
    t_read_turn();
    t_flip();
    t_idle_blank();
    t_same_cycle();
    t_swap_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule